// File: doc/BRIEF.md
# Exception status control slice

This block is the system-control register slice of a small 32-bit scalar core. It keeps the processor mode word, the exception cause word and the saved return address, plus a bank of plain storage registers for every other system-register index. When the pipeline reports a trap (system call, breakpoint or any other coded fault), the block saves the faulting address, records the cause, pushes the mode and interrupt-enable stack and asks the fetch stage to redirect to a single exception vector.

The mode word's low six bits form a three-deep stack of (kernel-mode, interrupt-enable) pairs. Trap entry pushes a cleared pair onto the stack, and a return-from-exception strobe pops it. Software can raise its own interrupts by setting two pending bits in the cause word. Whenever the mode word or the cause word is written, or a return-from-exception pops the stack, the block looks at these bits again in the next cycle and takes an interrupt if one is both pending and enabled. A status write that flips the cache-isolate bit produces a one-cycle notice for the memory side.

Top module: `sysctl_exc_ctrl`

## Requirements
- R1: After reset the mode word, the cause word, the saved address and every storage register read as zero, and `redirect`, `cache_iso` and `cache_iso_chg` are low.
- R2: A trap request (`exc_req`) raises `redirect` for exactly the next cycle, with `redirect_pc` giving the vector. In the same edge, mode-word bits 5:0 become the old bits 3:0 followed by two zero bits.
- R3: On trap entry the cause word (index 13) takes the trap code in bits 6:2 and the delay-slot flag in bit 31, and keeps all its other bits. A system call uses code 8 (cause 0x20) and a breakpoint uses code 9 (cause 0x24).
- R4: On trap entry the saved address (index 14) receives `exc_pc`, or `exc_pc` minus 4 when `exc_in_delay` is set.
- R5: A return-from-exception strobe sets mode-word bits 3:0 to the old bits 5:2 and leaves bits 31:4 unchanged.
- R6: A register write to the cause word changes only bits 9:8, which are the two software-interrupt pending bits.
- R7: A write to the mode word (index 12) stores the full value. `cache_iso` follows mode bit 16. `cache_iso_chg` pulses for one cycle after a write that flips bit 16, and stays low after a write that does not.
- R8: In the cycle after a mode write, a cause write or a return-from-exception, the block takes a software interrupt if (cause AND mode AND 0x300) is non-zero and mode bit 0 is set. This entry behaves like R2 and R4, writes code 0 to cause bits 6:2, and raises `redirect` two cycles after the triggering event.
- R9: A write to any other index stores the value unchanged in that index. `reg_rdata` returns the current contents of the index on `reg_ridx` in the same cycle.
- R10: Priority within one cycle runs trap entry (requested or software), then return-from-exception, then register write. A lower-priority action that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Trap request from the pipeline |
| exc_code | input | 5 | Trap code for cause bits 6:2 |
| exc_pc | input | 32 | Address of the instruction at the commit point |
| exc_in_delay | input | 1 | That instruction sits in a branch delay slot |
| rfe | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | System-register write strobe |
| reg_widx | input | 5 | Write index |
| reg_wdata | input | 32 | Write data |
| reg_ridx | input | 5 | Read index |
| reg_rdata | output | 32 | Read data for reg_ridx |
| redirect | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Exception vector address |
| status | output | 32 | Current mode word |
| cache_iso | output | 1 | Cache-isolate level (mode bit 16) |
| cache_iso_chg | output | 1 | One-cycle notice that the isolate level flipped |

## Verification
Every register update lands on the edge that accepts the request, so the stored words, `status` and `cache_iso` can be read back on the following falling edge. `redirect` and `cache_iso_chg` come from a flop and so also appear one edge after the trap or the write. A software interrupt is the exception: it shows up as `redirect` only on the second edge after the write or return that arms it, because the arming flag costs one extra register. The bench drives inputs on falling edges and samples on the falling edge after each active edge. For the armed interrupt it first confirms that `redirect` is still low after one edge, then checks that it is high after the next.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int unsigned SYS_W        = 32;
   localparam int unsigned CODE_W       = 5;
   localparam int unsigned CODE_LO      = 2;
   localparam int unsigned SWI_LO       = 8;
   localparam int unsigned SWI_W        = 2;
   localparam int unsigned BD_BIT       = 31;
   localparam int unsigned ISO_BIT      = 16;
   localparam int unsigned IE_BIT       = 0;
   localparam logic [CODE_W-1:0] CODE_IRQ     = 5'd0;
   localparam logic [CODE_W-1:0] CODE_SYSCALL = 5'd8;
   localparam logic [CODE_W-1:0] CODE_BREAK   = 5'd9;

   typedef struct packed {
      logic              bd;
      logic [CODE_W-1:0] code;
      logic [SYS_W-1:0]  pc;
   } entry_t;
endpackage

// File: rtl/sysctl_mode_stack.sv
module sysctl_mode_stack #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned LEVELS  = 3,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] status_q
);
   localparam int unsigned STK_W = 2 * LEVELS;

   generate
      if (LEVELS < 2) begin : g_bad_levels
         $error("sysctl_mode_stack: LEVELS must be at least 2");
      end
      if (STK_W > DATA_W) begin : g_bad_width
         $error("sysctl_mode_stack: stack wider than the register");
      end
   endgenerate

   logic [STK_W-1:0] pushed;
   logic [STK_W-1:0] popped;

   assign pushed[1:0] = 2'b00;
   assign popped[STK_W-1:STK_W-2] = status_q[STK_W-1:STK_W-2];

   generate
      for (genvar k = 1; k < LEVELS; k++) begin : g_push
         assign pushed[2*k+1:2*k] = status_q[2*k-1:2*k-2];
      end
      for (genvar k = 0; k < LEVELS - 1; k++) begin : g_pop
         assign popped[2*k+1:2*k] = status_q[2*k+3:2*k+2];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= RST_VAL;
      end else if (push) begin
         status_q[STK_W-1:0] <= pushed;
      end else if (pop) begin
         status_q[STK_W-1:0] <= popped;
      end else if (wr_en) begin
         status_q <= wr_data;
      end
   end
endmodule

// File: rtl/sysctl_cause_reg.sv
module sysctl_cause_reg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CODE_LO = 2,
   parameter int unsigned CODE_W  = 5,
   parameter int unsigned SWI_LO  = 8,
   parameter int unsigned SWI_W   = 2,
   parameter int unsigned BD_BIT  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter,
   input  logic [CODE_W-1:0] enter_code,
   input  logic              enter_bd,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cause_q
);
   generate
      if (CODE_LO + CODE_W > SWI_LO) begin : g_bad_fields
         $error("sysctl_cause_reg: code field overlaps pending bits");
      end
      if (BD_BIT >= DATA_W || SWI_LO + SWI_W > BD_BIT) begin : g_bad_bd
         $error("sysctl_cause_reg: delay-slot bit misplaced");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else if (enter) begin
         cause_q[CODE_LO +: CODE_W] <= enter_code;
         cause_q[BD_BIT]            <= enter_bd;
      end else if (wr_en) begin
         cause_q[SWI_LO +: SWI_W]   <= wr_data[SWI_LO +: SWI_W];
      end
   end
endmodule

// File: rtl/sysctl_swint_detect.sv
module sysctl_swint_detect #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned SWI_LO = 8,
   parameter int unsigned SWI_W  = 2,
   parameter int unsigned IE_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rearm,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] cause,
   output logic              fire
);
   logic             arm_q;
   logic [SWI_W-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= rearm;
   end

   assign hit  = status[SWI_LO +: SWI_W] & cause[SWI_LO +: SWI_W];
   assign fire = arm_q & (|hit) & status[IE_BIT];
endmodule

// File: rtl/sysctl_store_bank.sv
module sysctl_store_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned COUNT  = 32,
   localparam int unsigned IDX_W = $clog2(COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [COUNT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < COUNT; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/sysctl_exc_ctrl.sv
module sysctl_exc_ctrl #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_COUNT  = 32,
   parameter int unsigned LEVELS     = 3,
   parameter int unsigned IDX_STATUS = 12,
   parameter int unsigned IDX_CAUSE  = 13,
   parameter int unsigned IDX_EPC    = 14,
   parameter logic [31:0] VECTOR_PC  = 32'h8000_0080,
   parameter bit          DELAY_ADJ  = 1'b1,
   localparam int unsigned IDX_W     = $clog2(REG_COUNT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   exc_req,
   input  logic [4:0]             exc_code,
   input  logic [31:0]            exc_pc,
   input  logic                   exc_in_delay,
   input  logic                   rfe,
   input  logic                   reg_wr,
   input  logic [4:0]             reg_widx,
   input  logic [31:0]            reg_wdata,
   input  logic [4:0]             reg_ridx,
   output logic [31:0]            reg_rdata,
   output logic                   redirect,
   output logic [31:0]            redirect_pc,
   output logic [31:0]            status,
   output logic                   cache_iso,
   output logic                   cache_iso_chg
);
   import sysctl_pkg::*;

   generate
      if (DATA_W != SYS_W) begin : g_bad_w
         $error("sysctl_exc_ctrl: DATA_W must equal the package word width");
      end
      if (IDX_W != 5) begin : g_bad_idx
         $error("sysctl_exc_ctrl: REG_COUNT must give five index bits");
      end
      if (IDX_STATUS >= REG_COUNT || IDX_CAUSE >= REG_COUNT || IDX_EPC >= REG_COUNT)
      begin : g_bad_map
         $error("sysctl_exc_ctrl: register index outside the bank");
      end
   endgenerate

   logic [DATA_W-1:0] status_q, cause_q, epc_q, bank_rd;
   logic sw_fire, sw_take, enter, rfe_ok, wr_ok;
   logic wr_status, wr_cause, wr_epc, wr_bank, rearm;
   entry_t ent;
   logic [DATA_W-1:0] epc_next;
   logic redirect_q, iso_chg_q;

   // priority: entry, then return, then register write
   assign sw_take   = sw_fire & ~exc_req;
   assign enter     = exc_req | sw_take;
   assign rfe_ok    = rfe & ~enter;
   assign wr_ok     = reg_wr & ~enter & ~rfe;
   assign wr_status = wr_ok && (reg_widx == IDX_W'(IDX_STATUS));
   assign wr_cause  = wr_ok && (reg_widx == IDX_W'(IDX_CAUSE));
   assign wr_epc    = wr_ok && (reg_widx == IDX_W'(IDX_EPC));
   assign wr_bank   = wr_ok & ~wr_status & ~wr_cause & ~wr_epc;
   assign rearm     = rfe_ok | wr_status | wr_cause;

   assign ent.bd   = exc_in_delay;
   assign ent.code = exc_req ? exc_code : CODE_IRQ;
   assign ent.pc   = exc_pc;

   generate
      if (DELAY_ADJ) begin : g_epc_adj
         assign epc_next = ent.bd ? (ent.pc - DATA_W'(4)) : ent.pc;
      end else begin : g_epc_raw
         assign epc_next = ent.pc;
      end
   endgenerate

   sysctl_mode_stack #(
      .DATA_W (DATA_W),
      .LEVELS (LEVELS),
      .RST_VAL('0)
   ) i_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (enter),
      .pop     (rfe_ok),
      .wr_en   (wr_status),
      .wr_data (reg_wdata),
      .status_q(status_q)
   );

   sysctl_cause_reg #(
      .DATA_W (DATA_W),
      .CODE_LO(CODE_LO),
      .CODE_W (CODE_W),
      .SWI_LO (SWI_LO),
      .SWI_W  (SWI_W),
      .BD_BIT (BD_BIT)
   ) i_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter     (enter),
      .enter_code(ent.code),
      .enter_bd  (ent.bd),
      .wr_en     (wr_cause),
      .wr_data   (reg_wdata),
      .cause_q   (cause_q)
   );

   sysctl_swint_detect #(
      .DATA_W(DATA_W),
      .SWI_LO(SWI_LO),
      .SWI_W (SWI_W),
      .IE_BIT(IE_BIT)
   ) i_swint (
      .clk   (clk),
      .rst_n (rst_n),
      .rearm (rearm),
      .status(status_q),
      .cause (cause_q),
      .fire  (sw_fire)
   );

   sysctl_store_bank #(
      .DATA_W(DATA_W),
      .COUNT (REG_COUNT)
   ) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_bank),
      .wr_idx (reg_widx),
      .wr_data(reg_wdata),
      .rd_idx (reg_ridx),
      .rd_data(bank_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q      <= '0;
         redirect_q <= 1'b0;
         iso_chg_q  <= 1'b0;
      end else begin
         redirect_q <= enter;
         iso_chg_q  <= wr_status & (reg_wdata[ISO_BIT] ^ status_q[ISO_BIT]);
         if (enter)       epc_q <= epc_next;
         else if (wr_epc) epc_q <= reg_wdata;
      end
   end

   always_comb begin
      if (reg_ridx == IDX_W'(IDX_STATUS))     reg_rdata = status_q;
      else if (reg_ridx == IDX_W'(IDX_CAUSE)) reg_rdata = cause_q;
      else if (reg_ridx == IDX_W'(IDX_EPC))   reg_rdata = epc_q;
      else                                    reg_rdata = bank_rd;
   end

   assign redirect      = redirect_q;
   assign redirect_pc   = VECTOR_PC;
   assign status        = status_q;
   assign cache_iso     = status_q[ISO_BIT];
   assign cache_iso_chg = iso_chg_q;
endmodule

// File: rtl/sysctl_exc_ctrl_chk.sv
module sysctl_exc_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        exc_req,
   input logic        rfe,
   input logic        take,
   input logic        redirect,
   input logic [31:0] status,
   input logic        cache_iso,
   input logic        cache_iso_chg
);
   // R2
   redirect_after_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> redirect);

   // R2
   stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> status[5:0] == {$past(status[3:0]), 2'b00});

   // R5
   stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe && !exc_req && !take) |=>
         (status[3:0] == $past(status[5:2])) && (status[31:4] == $past(status[31:4])));

   // R7
   iso_notice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_iso_chg |-> cache_iso != $past(cache_iso));

   // R8
   redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> $past(exc_req || take));
endmodule

bind sysctl_exc_ctrl sysctl_exc_ctrl_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exc_req      (exc_req),
   .rfe          (rfe),
   .take         (sw_take),
   .redirect     (redirect),
   .status       (status),
   .cache_iso    (cache_iso),
   .cache_iso_chg(cache_iso_chg)
);

// File: tb/test_sysctl_exc_ctrl.sv
module test_sysctl_exc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [31:0] exc_pc = 32'h0000_1000;
   logic        exc_in_delay = 1'b0;
   logic        rfe = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_widx = '0;
   logic [31:0] reg_wdata = '0;
   logic [4:0]  reg_ridx = '0;
   logic [31:0] reg_rdata;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic [31:0] status;
   logic        cache_iso;
   logic        cache_iso_chg;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sysctl_exc_ctrl i_sysctl_exc_ctrl (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
      .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .rfe(rfe),
      .reg_wr(reg_wr), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
      .reg_ridx(reg_ridx), .reg_rdata(reg_rdata), .redirect(redirect),
      .redirect_pc(redirect_pc), .status(status), .cache_iso(cache_iso),
      .cache_iso_chg(cache_iso_chg)
   );

   // op: 0 write, 1 trap, 2 return, 3 idle
   // fields: op[76:75] bd[74] idx[73:69] data[68:37] rdidx[36:32] exp[31:0]
   localparam int NVEC = 11;
   localparam logic [76:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 5'd12, 32'h0000_0003, 5'd12, 32'h0000_0003},  // R7 no toggle
      {2'd1, 1'b0, 5'd8,  32'h8000_0100, 5'd12, 32'h0000_000C},  // R2 push
      {2'd3, 1'b0, 5'd0,  32'h0,         5'd13, 32'h0000_0020},  // R3 syscall
      {2'd3, 1'b0, 5'd0,  32'h0,         5'd14, 32'h8000_0100},  // R4
      {2'd2, 1'b0, 5'd0,  32'h0,         5'd12, 32'h0000_0003},  // R5 pop
      {2'd1, 1'b1, 5'd9,  32'h8000_0200, 5'd14, 32'h8000_01FC},  // R4 delay slot
      {2'd3, 1'b0, 5'd0,  32'h0,         5'd13, 32'h8000_0024},  // R3 break + bd
      {2'd3, 1'b0, 5'd0,  32'h0,         5'd12, 32'h0000_000C},  // R2
      {2'd0, 1'b0, 5'd13, 32'hFFFF_FFFF, 5'd13, 32'h8000_0324},  // R6
      {2'd0, 1'b0, 5'd5,  32'hDEAD_BEEF, 5'd5,  32'hDEAD_BEEF},  // R9
      {2'd0, 1'b0, 5'd12, 32'h0001_0000, 5'd12, 32'h0001_0000}   // R7 toggle
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] idx, output logic [31:0] val);
      reg_ridx = idx;
      #1;
      val = reg_rdata;
   endtask

   task automatic clear_inputs();
      exc_req = 1'b0; exc_code = '0; exc_pc = 32'h0000_1000; exc_in_delay = 1'b0;
      rfe = 1'b0; reg_wr = 1'b0; reg_widx = '0; reg_wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual=%0d expected=<5000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", status, 32'h0);
      check("R1 redirect", {31'h0, redirect}, 32'h0);
      check("R1 cache_iso", {30'h0, cache_iso, cache_iso_chg}, 32'h0);
      rd(5'd13, v); check("R1 cause", v, 32'h0);
      rd(5'd14, v); check("R1 epc", v, 32'h0);
      check("R2 vector", redirect_pc, 32'h8000_0080);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] op;
         op = VEC[i][76:75];
         case (op)
            2'd0: begin reg_wr = 1'b1; reg_widx = VEC[i][73:69]; reg_wdata = VEC[i][68:37]; end
            2'd1: begin exc_req = 1'b1; exc_code = VEC[i][73:69];
                        exc_pc = VEC[i][68:37]; exc_in_delay = VEC[i][74]; end
            2'd2: rfe = 1'b1;
            default: ;
         endcase
         @(negedge clk);
         clear_inputs();
         check($sformatf("R2 redirect vec%0d", i), {31'h0, redirect}, {31'h0, op == 2'd1});
         rd(VEC[i][36:32], v);
         check($sformatf("R3/R9 table vec%0d", i), v, VEC[i][31:0]);
      end

      // R7 toggle notice after last vector, then it clears
      check("R7 iso level", {31'h0, cache_iso}, 32'h1);
      check("R7 iso pulse", {31'h0, cache_iso_chg}, 32'h1);
      @(negedge clk);
      check("R7 iso pulse ends", {31'h0, cache_iso_chg}, 32'h0);
      reg_wr = 1'b1; reg_widx = 5'd12; reg_wdata = 32'h0001_0000;
      @(negedge clk); clear_inputs();
      check("R7 no flip no pulse", {31'h0, cache_iso_chg}, 32'h0);

      // R8 software interrupt armed by a mode write
      reg_wr = 1'b1; reg_widx = 5'd12; reg_wdata = 32'h0000_0101;
      @(negedge clk); clear_inputs();
      check("R7 flip back pulse", {31'h0, cache_iso_chg}, 32'h1);
      check("R8 not yet", {31'h0, redirect}, 32'h0);
      @(negedge clk);
      check("R8 redirect", {31'h0, redirect}, 32'h1);
      check("R8 status push", status, 32'h0000_0104);
      rd(5'd13, v); check("R8 cause code 0", v, 32'h0000_0300);
      rd(5'd14, v); check("R8 epc", v, 32'h0000_1000);

      // R8 re-evaluation after a return
      rfe = 1'b1;
      @(negedge clk); clear_inputs();
      check("R5 pop", status, 32'h0000_0101);
      check("R8 no redirect yet", {31'h0, redirect}, 32'h0);
      @(negedge clk);
      check("R8 redirect after return", {31'h0, redirect}, 32'h1);
      check("R8 status again", status, 32'h0000_0104);

      // R10 trap beats a write in the same cycle
      exc_req = 1'b1; exc_code = 5'd8; exc_pc = 32'h0000_2000;
      reg_wr = 1'b1; reg_widx = 5'd5; reg_wdata = 32'h1234_5678;
      @(negedge clk); clear_inputs();
      rd(5'd5, v); check("R10 write dropped", v, 32'hDEAD_BEEF);
      check("R10 status push", status, 32'h0000_0110);
      rd(5'd13, v); check("R10 cause", v, 32'h0000_0320);

      // R10 return beats a mode write
      rfe = 1'b1; reg_wr = 1'b1; reg_widx = 5'd12; reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk); clear_inputs();
      check("R10 return wins", status, 32'h0000_0114);
      @(negedge clk);
      check("R10 no interrupt", {31'h0, redirect}, 32'h0);

      finish_run();
   end
endmodule